// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Write Lock

This block is a watchdog down-counter that advances on a slow time-base tick (nominally 32 Hz, so one count is 31.25 ms). Software controls it through a single byte-wide register: one bit restarts the count, one bit locks the timeout field against writes, and a 6-bit field holds the timeout in ticks. A value of 1 gives 31.25 ms and 3Fh gives about 2 s. If software fails to restart the count before it reaches zero, the block raises a one-cycle timeout event and sets a sticky flag. The flag clears when the flags register that holds it is read. The count advances only while the oscillator enable input is high.

Timeout values are staged. A write lands in the visible timeout field, and the field is copied into an internal load register on the next qualified tick. A restart always reloads from the load register. A load value of zero disables the watchdog. After a timeout the counter stays at zero until it is restarted, so it never fires twice from one restart.

Top module: `wdt_guard`

## Requirements
- R1: After reset, rd_data_o reads 44h (lock bit 6 = 1, timeout field = 4, bit 7 = 0), flag_o and timeout_o are 0, and the counter starts at 4.
- R2: Register layout: bit 7 is the restart strobe, bit 6 is the lock (1 = timeout field protected), bits 5:0 are the timeout. Bit 7 of rd_data_o always reads 0.
- R3: Every write updates the lock bit. Bits 5:0 are written only if the lock bit was already 0 before that write. While it is 1, the field keeps its value.
- R4: A write with bit 7 = 1 reloads the counter from the load register and restarts the count. A write with bit 7 = 0 leaves the count unchanged.
- R5: The timeout field is copied into the load register on the next qualified tick, not at the write. A restart issued before that tick uses the previous value.
- R6: The counter and the load register change on a tick only while osc_en_i is 1. Ticks with osc_en_i = 0 are ignored.
- R7: The qualified tick that moves the counter from 1 to 0 pulses timeout_o for one cycle and sets flag_o at the same edge. A restart from value N times out on the Nth following tick.
- R8: A cycle with flag_rd_i = 1 clears flag_o at the next edge. If a timeout occurs in that same cycle, the flag is set instead.
- R9: After a timeout the counter holds at 0, and further ticks give no timeout until the next restart.
- R10: With a load value of 0 the watchdog is disabled: no tick produces a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register readback |
| osc_en_i | input | 1 | Oscillator running; qualifies ticks |
| tick_i | input | 1 | Time-base tick, one clock cycle wide |
| flag_rd_i | input | 1 | Flags register read; clears the flag |
| flag_o | output | 1 | Sticky watchdog flag |
| timeout_o | output | 1 | One-cycle timeout event |

## Verification
The assertions check the following on every cycle:
- counter and load register stay still without a qualified tick or restart;
- the zero count holds;
- a locked field survives writes;
- the flag clears after a read with no timeout in that cycle;
- every timeout sets the flag;
- a zero load value never expires;
- the timeout never lasts two cycles.

Only the bench scenarios can show:
- the exact tick count to a timeout;
- that a restart uses the old load value before the staging tick;
- the two-write unlock sequence;
- set-over-clear priority of the flag when the read and the timeout coincide.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned STB_BIT  = 7;
  localparam int unsigned LOCK_BIT = 6;
  localparam int unsigned REG_W    = 8;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_W    = 6,
  parameter int unsigned INIT_TMO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             step_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [TMO_W-1:0] load_o,
  output logic             strobe_o
);
  logic [TMO_W-1:0] field_q, load_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= TMO_W'(INIT_TMO);
      load_q  <= TMO_W'(INIT_TMO);
      lock_q  <= 1'b1;
    end else begin
      if (wr_en_i) begin
        lock_q <= wr_data_i[LOCK_BIT];
        // field accepts data only when unlocked before this write
        if (!lock_q) field_q <= wr_data_i[TMO_W-1:0];
      end
      if (step_i) load_q <= field_q;
    end
  end

  assign strobe_o  = wr_en_i & wr_data_i[STB_BIT];
  assign load_o    = load_q;
  assign rd_data_o = {1'b0, lock_q, field_q};

  // R3
  field_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && lock_q) |=> $stable(field_q));
  // R5
  load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(load_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned TMO_W    = 6,
  parameter int unsigned INIT_TMO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             strobe_i,
  input  logic [TMO_W-1:0] load_i,
  output logic             expire_o
);
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q;
  logic             armed;

  assign armed    = (load_i != '0);
  assign expire_o = step_i & ~strobe_i & armed & (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cnt_q <= TMO_W'(INIT_TMO);
    else if (strobe_i)                              cnt_q <= load_i;
    else if (step_i && armed && (cnt_q != '0))      cnt_q <= cnt_q - ONE;
  end

  // R6
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !strobe_i) |=> $stable(cnt_q));
  // R9
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !strobe_i) |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic event_o
);
  logic flag_q, evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q  <= set_i;
      // set wins over a coincident read-clear
      flag_q <= set_i | (flag_q & ~clr_i);
    end
  end

  assign flag_o  = flag_q;
  assign event_o = evt_q;

  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (flag_q && evt_q));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_W    = 6,
  parameter int unsigned INIT_TMO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             osc_en_i,
  input  logic             tick_i,
  input  logic             flag_rd_i,
  output logic             flag_o,
  output logic             timeout_o
);
  logic             step;
  logic             strobe;
  logic             expire;
  logic [TMO_W-1:0] load;

  assign step = tick_i & osc_en_i;

  wdt_ctrl_reg #(.TMO_W(TMO_W), .INIT_TMO(INIT_TMO)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .step_i(step), .rd_data_o, .load_o(load), .strobe_o(strobe)
  );

  wdt_counter #(.TMO_W(TMO_W), .INIT_TMO(INIT_TMO)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .strobe_i(strobe),
    .load_i(load), .expire_o(expire)
  );

  wdt_flag u_flag (
    .clk_i, .rst_ni, .set_i(expire), .clr_i(flag_rd_i),
    .flag_o, .event_o(timeout_o)
  );

  // R10
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load == '0) |-> !expire);
  // R9
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       osc_en_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       flag_rd_i = 1'b0;
  logic       flag_o, timeout_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_guard uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic tick(output logic to);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; to = timeout_o;
  endtask

  task automatic clear_flag();
    @(negedge clk_i); flag_rd_i = 1'b1;
    @(negedge clk_i); flag_rd_i = 1'b0;
  endtask

  // ticks n times; expects a timeout exactly on tick fire_at (0 = never)
  task automatic run_ticks(input string req, input int n, input int fire_at);
    logic to;
    int   bad = 0;
    for (int i = 1; i <= n; i++) begin
      tick(to);
      if (to !== (i == fire_at)) bad = i;
    end
    check(req, 8'(bad), 8'h00);
  endtask

  task automatic t_reset();
    check("R1 readback", rd_data_o, 8'h44);
    check("R1 flag", {7'b0, flag_o}, 8'h00);
    check("R1 timeout", {7'b0, timeout_o}, 8'h00);
  endtask

  task automatic t_first_timeout();
    run_ticks("R1 R7 power-up count", 4, 4);
    check("R7 flag set", {7'b0, flag_o}, 8'h01);
    run_ticks("R9 hold at zero", 6, 0);
    clear_flag();
    check("R8 flag cleared", {7'b0, flag_o}, 8'h00);
  endtask

  task automatic t_lock();
    wr(8'h4A);
    check("R3 locked field", rd_data_o, 8'h44);
    wr(8'h0A);
    check("R3 unlock write ignored", rd_data_o, 8'h04);
    wr(8'h0A);
    check("R3 field written", rd_data_o, 8'h0A);
  endtask

  task automatic t_staging();
    wr(8'h8A); // restart with old load value 4
    check("R2 strobe reads 0", rd_data_o, 8'h0A);
    run_ticks("R5 old value used", 4, 4);
    wr(8'hCA);
    check("R2 readback", rd_data_o, 8'h4A);
    run_ticks("R5 new value used", 10, 10);
    clear_flag();
  endtask

  task automatic t_kick();
    wr(8'hC0);
    run_ticks("R4 kick before expiry", 8, 0);
    wr(8'hC0);
    run_ticks("R4 second kick", 8, 0);
    wr(8'hC0);
    run_ticks("R4 part", 5, 0);
    wr(8'h40); // no strobe
    run_ticks("R4 strobe 0 no effect", 5, 5);
    check("R4 field kept", rd_data_o, 8'h4A);
    clear_flag();
  endtask

  task automatic t_osc();
    wr(8'hC0);
    osc_en_i = 1'b0;
    run_ticks("R6 ticks ignored", 20, 0);
    osc_en_i = 1'b1;
    run_ticks("R6 resumed", 10, 10);
    clear_flag();
  endtask

  task automatic t_disable();
    wr(8'h00);
    wr(8'h00);
    check("R10 field zero", rd_data_o, 8'h00);
    run_ticks("R10 stage", 1, 0);
    wr(8'h80);
    run_ticks("R10 disabled", 80, 0);
    check("R10 no flag", {7'b0, flag_o}, 8'h00);
  endtask

  task automatic t_priority();
    logic to;
    wr(8'h01);
    run_ticks("R5 stage one", 1, 0);
    wr(8'h81);
    @(negedge clk_i); tick_i = 1'b1; flag_rd_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; flag_rd_i = 1'b0; to = timeout_o;
    check("R7 timeout on one", {7'b0, to}, 8'h01);
    check("R8 set beats clear", {7'b0, flag_o}, 8'h01);
    @(negedge clk_i);
    check("R7 single pulse", {7'b0, timeout_o}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_first_timeout();
    t_lock();
    t_staging();
    t_kick();
    t_osc();
    t_disable();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule